// File: doc/BRIEF.md
# Byte-Strobed Register Bank Slave

This block is a small bank of 32-bit control registers that sits behind a lightweight AXI-style slave port. The port has five separate channels: write address, write data, write response, read address and read data. Each channel uses a valid/ready handshake, and a transfer happens on a rising clock edge where both valid and ready are high.

A write lands only in the byte lanes whose strobe bit is set. The other bytes of the addressed register keep their old contents. This lets narrow masters update a single byte or half-word without a read-modify-write cycle. The write address and the write data may arrive together, or either one may arrive first. The bank holds whichever half came first until the other half arrives, performs the write, and then raises one write response. It accepts no new write until that response has been taken.

A read returns the whole register word on the cycle after the address is accepted. Addresses beyond the last register answer with an error response and never alter storage. Every response stays on the bus, unchanged, until the master takes it.

Top module: `strobe_reg_bank`

## Requirements
- R1: After reset, `b_valid` and `r_valid` are low, `aw_ready`, `w_ready` and `ar_ready` are high, and every register reads as zero.
- R2: A write updates bits [8k+7:8k] of the addressed register only when `w_strb[k]` is 1. For example, a strobe of 4'b0010 changes only bits 15:8, and a strobe of 0 changes nothing.
- R3: The write address and the write data may be accepted in the same cycle, address first, or data first. The register is written in the cycle in which the later of the two is accepted.
- R4: `b_valid` rises on the cycle after the write completes. There is exactly one response per write. While `b_valid` is high, `aw_ready` and `w_ready` are low.
- R5: Once `b_valid` is high, it and `b_resp` hold steady until a cycle in which `b_ready` is high.
- R6: `r_valid` rises on the cycle after a read address is accepted. `r_data` holds the full register word and `r_resp` is 2'b00 (OKAY). `r_valid`, `r_data` and `r_resp` hold until `r_ready` is high. `ar_ready` is low while `r_valid` is high.
- R7: An address at or above 0x20 is out of range. A write to it returns `b_resp` 2'b10 (SLVERR) and changes no register. A read from it returns `r_resp` 2'b10 with `r_data` zero. In-range writes answer 2'b00.
- R8: The register index is taken from address bits 4:2. Address bits 1:0 are ignored.
- R9: After a write address has been accepted, `aw_ready` stays low until that write's response has been taken. The same rule applies to `w_ready` after write data has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | 8 | Write byte address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 32 | Write data word |
| w_strb | input | 4 | Byte lane enables for the write |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response code (00 OKAY, 10 SLVERR) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | 8 | Read byte address |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | 32 | Read data word |
| r_resp | output | 2 | Read response code (00 OKAY, 10 SLVERR) |

## Verification
The hardest situation to reach is a half-captured write. In that case one of address or data is parked inside the bank while a read, a stalled response and the missing half all meet in the same few cycles. The stimulus deliberately sends the address or the data first, with idle gaps in between. It also runs reads in a parallel thread and holds `b_ready` and `r_ready` low, either for fixed stretches or on random cycles. A cycle-level reference model then predicts every ready, valid, response and data value at each clock, and each of those predictions is compared with the bank's outputs.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

endpackage

// File: rtl/srb_regfile.sv
module srb_regfile
    import srb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned STRB_W  = DATA_W / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0]   regs_d [NUM_REGS];
    logic [DATA_W-1:0]   regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] row_sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
        assign row_sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            regs_d[r] = regs_q[r];
            for (int l = 0; l < STRB_W; l++) begin
                if (row_sel[r] && wr_strb[l]) begin
                    regs_d[r][l*BYTE_W +: BYTE_W] = wr_data[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs_q[r] <= regs_d[r];
            end
        end
    end

    assign rd_word = regs_q[rd_idx];

endmodule

// File: rtl/srb_wr_chan.sv
module srb_wr_chan
    import srb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned STRB_W  = DATA_W / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned LSB     = $clog2(STRB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);

    typedef struct packed {
        logic              aw_have;
        logic [ADDR_W-1:0] addr;
        logic              w_have;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              b_valid;
        resp_e             b_resp;
    } wr_state_t;

    wr_state_t         st_d, st_q;
    logic              aw_fire, w_fire, have_aw, have_w, in_range;
    logic [ADDR_W-1:0] addr_now;

    always_comb begin
        st_d     = st_q;
        aw_ready = !st_q.aw_have && !st_q.b_valid;
        w_ready  = !st_q.w_have && !st_q.b_valid;
        aw_fire  = aw_valid && aw_ready;
        w_fire   = w_valid && w_ready;
        have_aw  = st_q.aw_have || aw_fire;
        have_w   = st_q.w_have || w_fire;
        addr_now = st_q.aw_have ? st_q.addr : aw_addr;
        wr_data  = st_q.w_have ? st_q.data : w_data;
        wr_strb  = st_q.w_have ? st_q.strb : w_strb;
        wr_idx   = addr_now[LSB +: IDX_W];
        in_range = (addr_now >> (LSB + IDX_W)) == '0;
        wr_en    = 1'b0;

        if (st_q.b_valid && b_ready) begin
            st_d.b_valid = 1'b0;
        end
        if (aw_fire) begin
            st_d.aw_have = 1'b1;
            st_d.addr    = aw_addr;
        end
        if (w_fire) begin
            st_d.w_have = 1'b1;
            st_d.data   = w_data;
            st_d.strb   = w_strb;
        end
        if (have_aw && have_w) begin
            wr_en        = in_range;
            st_d.aw_have = 1'b0;
            st_d.w_have  = 1'b0;
            st_d.b_valid = 1'b1;
            st_d.b_resp  = in_range ? RESP_OKAY : RESP_SLVERR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{aw_have: 1'b0, addr: '0, w_have: 1'b0, data: '0,
                      strb: '0, b_valid: 1'b0, b_resp: RESP_OKAY};
        end else begin
            st_q <= st_d;
        end
    end

    assign b_valid = st_q.b_valid;
    assign b_resp  = st_q.b_resp;

endmodule

// File: rtl/srb_rd_chan.sv
module srb_rd_chan
    import srb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned STRB_W  = DATA_W / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned LSB     = $clog2(STRB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_word
);

    typedef struct packed {
        logic              r_valid;
        logic [DATA_W-1:0] data;
        resp_e             resp;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      ar_fire, in_range;

    always_comb begin
        st_d     = st_q;
        ar_ready = !st_q.r_valid;
        ar_fire  = ar_valid && ar_ready;
        rd_idx   = ar_addr[LSB +: IDX_W];
        in_range = (ar_addr >> (LSB + IDX_W)) == '0;

        if (st_q.r_valid && r_ready) begin
            st_d.r_valid = 1'b0;
        end
        if (ar_fire) begin
            st_d.r_valid = 1'b1;
            st_d.data    = in_range ? rd_word : '0;
            st_d.resp    = in_range ? RESP_OKAY : RESP_SLVERR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{r_valid: 1'b0, data: '0, resp: RESP_OKAY};
        end else begin
            st_q <= st_d;
        end
    end

    assign r_valid = st_q.r_valid;
    assign r_data  = st_q.data;
    assign r_resp  = st_q.resp;

endmodule

// File: rtl/strobe_reg_bank.sv
module strobe_reg_bank
    import srb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned STRB_W  = DATA_W / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp
);

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] wr_data, rd_word;
    logic [STRB_W-1:0] wr_strb;

    srb_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) wr_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    srb_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    srb_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rd_i (
        .clk(clk), .rst_n(rst_n),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

endmodule

// File: rtl/srb_chk.sv
module srb_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic              w_valid,
    input logic              w_ready,
    input logic              b_valid,
    input logic              b_ready,
    input logic [1:0]        b_resp,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic              r_valid,
    input logic              r_ready,
    input logic [DATA_W-1:0] r_data,
    input logic [1:0]        r_resp
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!b_valid && !r_valid));

    // R3
    pair_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && w_valid && w_ready) |=> b_valid);

    // R4
    b_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (!aw_ready && !w_ready));

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

    // R6
    r_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> r_valid);

    // R6
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)));

    // R6
    ar_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> !ar_ready);

    // R9
    aw_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> !aw_ready);

    // R9
    w_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready) |=> !w_ready);

endmodule

bind strobe_reg_bank srb_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp)
);

// File: tb/strobe_reg_bank_tb.sv
module strobe_reg_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0, w_valid = 1'b0, ar_valid = 1'b0;
    logic        b_ready = 1'b1, r_ready = 1'b1;
    logic [7:0]  aw_addr = '0, ar_addr = '0;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
    logic [1:0]  b_resp, r_resp;
    logic [31:0] r_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int rdy_mode = 0;  // 0 always ready, 1 random, 2 held low

    strobe_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_regs [NREG];
    bit          m_awh, m_wh, m_bv, m_rv;
    logic [7:0]  m_a;
    logic [31:0] m_d, m_rd;
    logic [3:0]  m_s;
    logic [1:0]  m_br, m_rr;

    always @(posedge clk) begin
        bit o_awr, o_wr, o_arr;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m_regs[i] = '0;
            m_awh = 0; m_wh = 0; m_bv = 0; m_rv = 0;
            m_br = 2'b00; m_rr = 2'b00; m_rd = '0;
        end else begin
            o_awr = !m_awh && !m_bv;
            o_wr  = !m_wh && !m_bv;
            o_arr = !m_rv;
            if (m_rv && r_ready) m_rv = 0;
            if (ar_valid && o_arr) begin
                m_rv = 1;
                if (int'(ar_addr) < NREG * 4) begin
                    m_rd = m_regs[int'(ar_addr) / 4];
                    m_rr = 2'b00;
                end else begin
                    m_rd = '0;
                    m_rr = 2'b10;
                end
            end
            if (m_bv && b_ready) m_bv = 0;
            if (aw_valid && o_awr) begin m_awh = 1; m_a = aw_addr; end
            if (w_valid && o_wr) begin m_wh = 1; m_d = w_data; m_s = w_strb; end
            if (m_awh && m_wh) begin
                if (int'(m_a) < NREG * 4) begin
                    for (int k = 0; k < 4; k++)
                        if (m_s[k]) m_regs[int'(m_a) / 4][8*k +: 8] = m_d[8*k +: 8];
                    m_br = 2'b00;
                end else begin
                    m_br = 2'b10;
                end
                m_bv = 1; m_awh = 0; m_wh = 0;
            end
        end
    end

    // per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(32'(aw_ready), 32'(!m_awh && !m_bv), "R9", "aw_ready");
            chk(32'(w_ready),  32'(!m_wh && !m_bv),  "R9", "w_ready");
            chk(32'(b_valid),  32'(m_bv),            "R4", "b_valid");
            if (m_bv) chk(32'(b_resp), 32'(m_br),    "R7", "b_resp");
            chk(32'(ar_ready), 32'(!m_rv),           "R6", "ar_ready");
            chk(32'(r_valid),  32'(m_rv),            "R6", "r_valid");
            if (m_rv) begin
                chk(r_data, m_rd,                    "R2", "r_data");
                chk(32'(r_resp), 32'(m_rr),          "R7", "r_resp");
            end
        end
    end

    // ready drivers
    initial begin
        forever begin
            @(posedge clk);
            #2;
            case (rdy_mode)
                0: begin b_ready = 1'b1; r_ready = 1'b1; end
                1: begin b_ready = 1'($urandom_range(0, 1)); r_ready = 1'($urandom_range(0, 1)); end
                default: begin b_ready = 1'b0; r_ready = 1'b0; end
            endcase
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_aw(input logic [7:0] a);
        bit f;
        aw_valid = 1'b1; aw_addr = a;
        do begin
            @(negedge clk); f = aw_ready;
            @(posedge clk); #2;
        end while (!f);
        aw_valid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] s);
        bit f;
        w_valid = 1'b1; w_data = d; w_strb = s;
        do begin
            @(negedge clk); f = w_ready;
            @(posedge clk); #2;
        end while (!f);
        w_valid = 1'b0;
    endtask

    task automatic wait_b(output logic [1:0] resp);
        bit f;
        do begin
            @(negedge clk); f = b_valid && b_ready; resp = b_resp;
            @(posedge clk); #2;
        end while (!f);
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int order, input int gap, output logic [1:0] resp);
        case (order)
            0: fork send_aw(a); send_w(d, s); join
            1: begin send_aw(a); repeat (gap) @(posedge clk); #2; send_w(d, s); end
            default: begin send_w(d, s); repeat (gap) @(posedge clk); #2; send_aw(a); end
        endcase
        wait_b(resp);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
        bit f;
        ar_valid = 1'b1; ar_addr = a;
        do begin
            @(negedge clk); f = ar_ready;
            @(posedge clk); #2;
        end while (!f);
        ar_valid = 1'b0;
        do begin
            @(negedge clk); f = r_valid && r_ready; d = r_data; resp = r_resp;
            @(posedge clk); #2;
        end while (!f);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at %0t", $time);
            summary();
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] rd;
        logic [1:0]  rs, br;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(32'(aw_ready), 1, "R1", "aw_ready after reset");
        chk(32'(w_ready),  1, "R1", "w_ready after reset");
        chk(32'(ar_ready), 1, "R1", "ar_ready after reset");
        chk(32'(b_valid),  0, "R1", "b_valid after reset");
        chk(32'(r_valid),  0, "R1", "r_valid after reset");
        @(posedge clk); #2;
        for (int i = 0; i < NREG; i++) begin
            do_read(8'(i * 4), rd, rs);
            chk(rd, 32'h0, "R1", "register zero after reset");
        end

        // R3 together, full word
        do_write(8'h00, 32'h11223344, 4'hF, 0, 0, br);
        chk(32'(br), 32'h0, "R7", "okay response in range");
        do_read(8'h00, rd, rs);
        chk(rd, 32'h11223344, "R3", "write with address and data together");
        chk(32'(rs), 32'h0, "R6", "read okay");

        // R2 byte lanes
        do_write(8'h00, 32'hAABBCCDD, 4'b0010, 0, 0, br);
        do_read(8'h00, rd, rs);
        chk(rd, 32'h1122CC44, "R2", "strobe 0010 touches bits 15:8 only");
        do_write(8'h00, 32'h55667788, 4'b1001, 0, 0, br);
        do_read(8'h00, rd, rs);
        chk(rd, 32'h5522CC88, "R2", "strobe 1001");
        do_write(8'h00, 32'hFFFFFFFF, 4'b0000, 0, 0, br);
        do_read(8'h00, rd, rs);
        chk(rd, 32'h5522CC88, "R2", "empty strobe changes nothing");

        // R3 address first, data first
        do_write(8'h0C, 32'hDEADBEEF, 4'hF, 1, 3, br);
        do_read(8'h0C, rd, rs);
        chk(rd, 32'hDEADBEEF, "R3", "address first");
        do_write(8'h1C, 32'h0BADF00D, 4'hF, 2, 4, br);
        do_read(8'h1C, rd, rs);
        chk(rd, 32'h0BADF00D, "R3", "data first");

        // R8 low address bits ignored
        do_write(8'h15, 32'hCAFEF00D, 4'hF, 0, 0, br);
        do_read(8'h16, rd, rs);
        chk(rd, 32'hCAFEF00D, "R8", "bits 1:0 ignored");

        // R7 out of range
        do_write(8'h20, 32'h12345678, 4'hF, 0, 0, br);
        chk(32'(br), 32'h2, "R7", "write out of range slverr");
        do_read(8'h20, rd, rs);
        chk(32'(rs), 32'h2, "R7", "read out of range slverr");
        chk(rd, 32'h0, "R7", "read out of range data zero");
        do_read(8'h00, rd, rs);
        chk(rd, 32'h5522CC88, "R7", "register untouched by out-of-range write");

        // R5 response held under stall
        rdy_mode = 2;
        @(posedge clk); #2;
        fork send_aw(8'h08); send_w(32'h00C0FFEE, 4'hF); join
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(32'(b_valid), 1, "R5", "b_valid held while not ready");
            chk(32'(b_resp), 32'h0, "R5", "b_resp stable");
        end
        rdy_mode = 0;
        wait_b(br);
        do_read(8'h08, rd, rs);
        chk(rd, 32'h00C0FFEE, "R6", "full word read back");

        // random traffic under back-pressure, concurrent reads
        rdy_mode = 1;
        for (int n = 0; n < 40; n++) begin
            fork
                begin
                    logic [1:0] b2;
                    do_write(8'($urandom_range(0, 39)), $urandom, 4'($urandom_range(0, 15)),
                             int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), b2);
                end
                begin
                    logic [31:0] d2;
                    logic [1:0]  r2;
                    do_read(8'($urandom_range(0, 39)), d2, r2);
                end
            join
        end
        rdy_mode = 0;
        repeat (3) @(posedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule